// File: doc/BRIEF.md
# Receive Descriptor Ring Start-of-Packet Scanner

This block walks a circular ring of receive descriptors for a network DMA engine and decides which buffer the next incoming frame goes into. Each descriptor carries an ownership flag (controller or host), a start-of-packet flag and a buffer pointer. The block reaches the ring through a single-cycle memory port: the read data for the entry on `mem_idx` is valid in the same cycle, and a write is taken on the next rising clock edge. The receive path tells the block when a frame begins and when the descriptors of a packet's first and last buffers have been written back. The block answers with a receive-interrupt pulse and the buffer to use next.

In plain mode the block takes descriptors in ring order. It waits on an entry until the controller owns it. In look-ahead mode, after a packet ends, it hunts forward for the next entry marked start-of-packet and ignores ownership while it does so. Skipped entries that the controller owns are handed back to the host. Skipped entries that the host owns are left alone. A start entry that the host still owns is polled. A start entry that the controller owns is latched as the next buffer. Look-ahead mode also raises an interrupt once the first buffer of a packet has been written back.

Top module: `rxr_stp_scanner`

## Requirements
- R1: While reset is applied, and until the synchronized reset releases, `rx_irq` and `buf_valid` are 0, `la_en` is 0 and `mem_idx` is entry 0.
- R2: With `la_en` = 0 the current entry is read (`mem_re` = 1). If its ownership bit (descriptor bit DESC_W-1, 1 = controller) is set, `buf_valid` rises with that pointer (bits PTR_W-1:0) and index. Otherwise the entry is read again after POLL_CYCLES idle cycles, so reads come every POLL_CYCLES+1 cycles.
- R3: With `la_en` = 1 the scan reads one entry per cycle and moves past every entry whose start-of-packet bit (bit DESC_W-2) is 0, whatever its ownership.
- R4: A skipped entry that the controller owns is written back in its read cycle with the ownership bit cleared and the other bits unchanged.
- R5: A skipped entry that the host owns is never written.
- R6: When the first start-of-packet entry found is host-owned, the scan stops on it and rereads that same entry every POLL_CYCLES+1 cycles.
- R7: When the first start-of-packet entry found is controller-owned, `buf_valid` rises one cycle later with its pointer and index. These hold unchanged until `ev_frame`.
- R8: During a frame, `ev_last_done` gives a one-cycle `rx_irq` in the next cycle. `ev_first_done` does the same only when `la_en` = 1 and is ignored when `la_en` = 0.
- R9: After `ev_last_done`, the next scan begins at `ev_last_idx`+1, with the index wrapping from RING_LEN-1 to 0.
- R10: If RING_LEN consecutive scan reads find no start-of-packet entry, the block polls the entry where that scan began.
- R11: `la_wr` loads `la_wdata` into the look-ahead bit, which is read back on `la_en`. `restart` returns the scan to entry 0, drops `buf_valid` and leaves `la_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| la_wr | input | 1 | Write strobe for the look-ahead bit |
| la_wdata | input | 1 | Value written to the look-ahead bit |
| la_en | output | 1 | Current look-ahead bit |
| restart | input | 1 | Return the scan to entry 0 |
| ev_frame | input | 1 | Frame arriving into the offered buffer |
| ev_first_done | input | 1 | First-buffer descriptor written back |
| ev_last_done | input | 1 | Last-buffer descriptor written back |
| ev_last_idx | input | IDX_W | Ring index of the packet's last descriptor |
| mem_re | output | 1 | Descriptor read in this cycle |
| mem_idx | output | IDX_W | Ring index being accessed |
| mem_rdata | input | PTR_W+2 | Descriptor at `mem_idx` (same cycle) |
| mem_we | output | 1 | Write `mem_wdata` to `mem_idx` at the next edge |
| mem_wdata | output | PTR_W+2 | Descriptor written back |
| rx_irq | output | 1 | Receive-interrupt pulse |
| buf_valid | output | 1 | Next buffer is latched and offered |
| buf_idx | output | IDX_W | Ring index of the offered buffer |
| buf_ptr | output | PTR_W | Pointer of the offered buffer |

## Verification
The assertions assume the following about the inputs:
- The ring memory returns the entry on `mem_idx` combinationally in the same cycle.
- The receive-path events arrive only between the block offering a buffer and the end of that frame.
- `ev_last_idx` is a valid ring index.

The stimulus keeps within these limits:
- The host changes descriptors only at the falling clock edge, so a scan read never sees a half-written entry.
- Events are driven one cycle at a time, and only after `buf_valid` has been seen and `ev_frame` given.
- Ring contents are chosen so that every skip, scrub, poll, wrap and full-lap stall path is reached.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_POLL  = 2'd1,
    ST_READY = 2'd2,
    ST_BUSY  = 2'd3
  } rxr_state_e;
endpackage

// File: rtl/rxr_ctl_bit.sv
module rxr_ctl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic q
);
  logic q_n;

  always_comb begin
    q_n = q;
    if (wr) q_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_n;
  end
endmodule

// File: rtl/rxr_poll_timer.sv
module rxr_poll_timer #(
  parameter int POLL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(POLL_CYCLES + 1);

  logic [CNT_W-1:0] cnt, cnt_n;

  assign done = run && (cnt == CNT_W'(POLL_CYCLES - 1));

  always_comb begin
    cnt_n = '0;
    if (run && !done) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int RING_LEN = 8,
  localparam int IDX_W = $clog2(RING_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  output logic [IDX_W-1:0] cur,
  output logic [IDX_W-1:0] start,
  output logic             lap_end
);
  logic [IDX_W-1:0] cur_n, start_n, cnt, cnt_n;

  assign lap_end = (cnt == IDX_W'(RING_LEN - 1));

  always_comb begin
    cur_n   = cur;
    start_n = start;
    cnt_n   = cnt;
    if (load) begin
      cur_n   = load_idx;
      start_n = load_idx;
      cnt_n   = '0;
    end else if (step) begin
      cur_n = cur + 1'b1;
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      start <= '0;
      cnt   <= '0;
    end else begin
      cur   <= cur_n;
      start <= start_n;
      cnt   <= cnt_n;
    end
  end
endmodule

// File: rtl/rxr_stp_scanner.sv
module rxr_stp_scanner
  import rxr_pkg::*;
#(
  parameter int RING_LEN    = 8,
  parameter int PTR_W       = 16,
  parameter int POLL_CYCLES = 16,
  localparam int IDX_W  = $clog2(RING_LEN),
  localparam int DESC_W = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              la_wr,
  input  logic              la_wdata,
  output logic              la_en,
  input  logic              restart,
  input  logic              ev_frame,
  input  logic              ev_first_done,
  input  logic              ev_last_done,
  input  logic [IDX_W-1:0]  ev_last_idx,
  output logic              mem_re,
  output logic [IDX_W-1:0]  mem_idx,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DESC_W-1:0] mem_wdata,
  output logic              rx_irq,
  output logic              buf_valid,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [PTR_W-1:0]  buf_ptr
);
  localparam int OWN_B = DESC_W - 1;
  localparam int STP_B = DESC_W - 2;

  // reset: asserted asynchronously, released on the second edge
  logic rs_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_ni  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_ni  <= rs_meta;
    end
  end

  rxr_state_e       state, state_n;
  logic [PTR_W-1:0] lat_ptr, ptr_n;
  logic             irq_q, irq_n;
  logic             la_q, poll_done, ld, stp_go, lap_end;
  logic [IDX_W-1:0] ld_idx, cur, start;

  rxr_ctl_bit u_la (
    .clk(clk), .rst_n(rst_ni), .wr(la_wr), .wdata(la_wdata), .q(la_q)
  );

  rxr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk(clk), .rst_n(rst_ni), .run(state == ST_POLL), .done(poll_done)
  );

  rxr_ring_ptr #(.RING_LEN(RING_LEN)) u_ring (
    .clk(clk), .rst_n(rst_ni), .load(ld), .load_idx(ld_idx), .step(stp_go),
    .cur(cur), .start(start), .lap_end(lap_end)
  );

  logic d_own, d_stp;
  assign d_own = mem_rdata[OWN_B];
  assign d_stp = mem_rdata[STP_B];

  always_comb begin
    state_n = state;
    ptr_n   = lat_ptr;
    irq_n   = 1'b0;
    ld      = 1'b0;
    ld_idx  = cur;
    stp_go  = 1'b0;
    if (restart) begin
      state_n = ST_SCAN;
      ld      = 1'b1;
      ld_idx  = '0;
    end else begin
      unique case (state)
        ST_SCAN: begin
          if (!la_q || d_stp) begin
            if (d_own) begin
              state_n = ST_READY;
              ptr_n   = mem_rdata[PTR_W-1:0];
            end else begin
              state_n = ST_POLL;
            end
          end else if (lap_end) begin
            state_n = ST_POLL;       // full lap: park on the entry the scan began at
            ld      = 1'b1;
            ld_idx  = start;
          end else begin
            stp_go = 1'b1;
          end
        end
        ST_POLL: begin
          if (poll_done) begin
            state_n = ST_SCAN;
            ld      = 1'b1;
            ld_idx  = cur;
          end
        end
        ST_READY: begin
          if (ev_frame) state_n = ST_BUSY;
        end
        ST_BUSY: begin
          irq_n = ev_last_done | (ev_first_done & la_q);
          if (ev_last_done) begin
            state_n = ST_SCAN;
            ld      = 1'b1;
            ld_idx  = ev_last_idx + 1'b1;
          end
        end
        default: state_n = ST_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_SCAN;
      lat_ptr <= '0;
      irq_q   <= 1'b0;
    end else begin
      state   <= state_n;
      lat_ptr <= ptr_n;
      irq_q   <= irq_n;
    end
  end

  assign la_en     = la_q;
  assign mem_re    = (state == ST_SCAN);
  assign mem_idx   = cur;
  assign mem_we    = mem_re && la_q && !d_stp && d_own && !restart;
  assign mem_wdata = {1'b0, mem_rdata[DESC_W-2:0]};
  assign rx_irq    = irq_q;
  assign buf_valid = (state == ST_READY);
  assign buf_idx   = cur;
  assign buf_ptr   = lat_ptr;

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_irq |-> $past(state == ST_BUSY));

  p_scrub_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (mem_rdata[OWN_B] && !mem_wdata[OWN_B] &&
                mem_wdata[PTR_W-1:0] == mem_rdata[PTR_W-1:0]));

  p_lap_stall_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_SCAN && la_q && !d_stp && lap_end && !restart)
      |=> (state == ST_POLL && cur == $past(start)));

  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_READY && !ev_frame && !restart)
      |=> (buf_valid && $stable(buf_ptr) && $stable(buf_idx)));

  p_la_keep_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (restart && !la_wr) |=> (la_en == $past(la_en)));
endmodule

// File: tb/sim_rxr_stp_scanner.sv
module sim_rxr_stp_scanner;
  localparam int N = 8;
  localparam int PW = 16;
  localparam int P = 4;
  localparam int DW = PW + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, la_wr, la_wdata, restart, ev_frame, ev_first, ev_last;
  logic [2:0] last_idx;
  logic la_en, mem_re, mem_we, rx_irq, buf_valid;
  logic [2:0] mem_idx, buf_idx;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic [PW-1:0] buf_ptr;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] mref [N];
  int tests = 0, fails = 0;
  bit finished = 0;

  assign mem_rdata = mem[mem_idx];
  always @(posedge clk) if (mem_we) mem[mem_idx] <= mem_wdata;

  rxr_stp_scanner #(.RING_LEN(N), .PTR_W(PW), .POLL_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .la_wr(la_wr), .la_wdata(la_wdata), .la_en(la_en),
    .restart(restart), .ev_frame(ev_frame), .ev_first_done(ev_first),
    .ev_last_done(ev_last), .ev_last_idx(last_idx), .mem_re(mem_re),
    .mem_idx(mem_idx), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .rx_irq(rx_irq), .buf_valid(buf_valid),
    .buf_idx(buf_idx), .buf_ptr(buf_ptr)
  );

  // behavioural reference: 0 scan, 1 poll, 2 ready, 3 busy
  int ms, mcur, mstart, msteps, mpoll, mptr, mirq, mla, rs;
  always @(posedge clk or negedge rst_n) begin
    logic [DW-1:0] d;
    int nla;
    if (!rst_n) begin
      rs = 0; ms = 0; mcur = 0; mstart = 0; msteps = 0; mpoll = 0;
      mptr = 0; mirq = 0; mla = 0;
    end else if (rs < 2) begin
      rs++;
    end else begin
      nla = la_wr ? int'(la_wdata) : mla;
      d = mref[mcur];
      mirq = 0;
      if (restart) begin
        ms = 0; mcur = 0; mstart = 0; msteps = 0;
      end else begin
        case (ms)
          0: begin
            if (mla == 0 || d[DW-2]) begin
              if (d[DW-1]) begin mptr = int'(d[PW-1:0]); ms = 2; end
              else begin ms = 1; mpoll = 0; end
            end else begin
              if (d[DW-1]) mref[mcur] = d & ~(DW'(1) << (DW-1));
              if (msteps == N-1) begin
                mcur = mstart; msteps = 0; ms = 1; mpoll = 0;
              end else begin
                mcur = (mcur + 1) % N; msteps++;
              end
            end
          end
          1: begin
            if (mpoll == P-1) begin ms = 0; mstart = mcur; msteps = 0; end
            else mpoll++;
          end
          2: if (ev_frame) ms = 3;
          default: begin
            mirq = (ev_last || (ev_first && mla != 0)) ? 1 : 0;
            if (ev_last) begin
              mcur = (int'(last_idx) + 1) % N; mstart = mcur; msteps = 0; ms = 0;
            end
          end
        endcase
      end
      mla = nla;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic [DW-1:0] d;
    @(negedge clk);
    d = mref[mcur];
    chk("R3 mem_idx", int'(mem_idx), mcur);
    chk("R6 mem_re", int'(mem_re), (ms == 0) ? 1 : 0);
    chk("R4 mem_we", int'(mem_we),
        (ms == 0 && mla != 0 && !d[DW-2] && d[DW-1] && !restart) ? 1 : 0);
    chk("R8 rx_irq", int'(rx_irq), mirq);
    chk("R7 buf_valid", int'(buf_valid), (ms == 2) ? 1 : 0);
    if (ms == 2) chk("R7 buf_ptr", int'(buf_ptr), mptr);
    chk("R11 la_en", int'(la_en), mla);
    for (int i = 0; i < N; i++) chk("R5 ring contents", int'(mem[i]), int'(mref[i]));
  endtask

  function automatic logic [DW-1:0] mk(input bit own, input bit stp, input int ptr);
    return {own, stp, PW'(ptr)};
  endfunction

  task automatic host_set(input int i, input logic [DW-1:0] d);
    mem[i] = d; mref[i] = d;
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!buf_valid && n < 60) begin cyc(); n++; end
    chk(tag, int'(buf_valid), 1);
  endtask

  task automatic frame_end(input int lidx, input bit first);
    ev_frame = 1; cyc(); ev_frame = 0;
    if (first) begin
      ev_first = 1; cyc(); ev_first = 0;
      chk("R8 first-buffer irq", int'(rx_irq), la_en ? 1 : 0);
    end
    last_idx = 3'(lidx); ev_last = 1; cyc(); ev_last = 0;
    chk("R8 last-buffer irq", int'(rx_irq), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int n;
    rst_n = 0; la_wr = 0; la_wdata = 0; restart = 0; ev_frame = 0;
    ev_first = 0; ev_last = 0; last_idx = 0;
    for (int i = 0; i < N; i++) host_set(i, '0);
    repeat (2) @(negedge clk);
    chk("R1 reset irq", int'(rx_irq), 0);
    chk("R1 reset buf_valid", int'(buf_valid), 0);
    chk("R1 reset la_en", int'(la_en), 0);
    chk("R1 reset idx", int'(mem_idx), 0);
    rst_n = 1;
    cyc(); cyc();
    chk("R1 held after release", int'(buf_valid), 0);

    // R2: plain mode polls a host-owned entry
    n = 0; while (!mem_re && n < 20) begin cyc(); n++; end
    cyc(); n = 1; while (!mem_re && n < 20) begin cyc(); n++; end
    chk("R2 plain poll period", n, P + 1);
    host_set(0, mk(1, 0, 'h1000));
    wait_ready("R2 plain ready");
    chk("R2 plain ptr", int'(buf_ptr), 'h1000);
    chk("R2 plain idx", int'(buf_idx), 0);
    frame_end(2, 1);
    cyc(); chk("R8 irq one cycle", int'(rx_irq), 0);
    chk("R9 next entry", int'(mem_idx), 3);
    host_set(3, mk(1, 0, 'h3000));
    wait_ready("R2 plain ready at 3");
    chk("R2 plain idx 3", int'(buf_idx), 3);

    // R11: enable look-ahead
    la_wr = 1; la_wdata = 1; cyc(); la_wr = 0;
    chk("R11 la write", int'(la_en), 1);

    // R3/R4/R5/R7: skip scrub and latch
    host_set(4, mk(1, 0, 'h4000));
    host_set(5, mk(0, 0, 'h5000));
    host_set(6, mk(1, 1, 'h6000));
    frame_end(3, 1);
    wait_ready("R7 lookahead ready");
    chk("R7 idx", int'(buf_idx), 6);
    chk("R7 ptr", int'(buf_ptr), 'h6000);
    chk("R4 scrubbed entry", int'(mem[4]), int'(mk(0, 0, 'h4000)));
    chk("R5 host entry kept", int'(mem[5]), int'(mk(0, 0, 'h5000)));
    repeat (3) cyc();
    chk("R7 held ptr", int'(buf_ptr), 'h6000);

    // R6: host-owned start entry is polled
    host_set(7, mk(0, 1, 'h7000));
    frame_end(6, 0);
    n = 0; while (!mem_re && n < 20) begin cyc(); n++; end
    cyc(); n = 1; while (!mem_re && n < 20) begin cyc(); n++; end
    chk("R6 poll period", n, P + 1);
    chk("R6 poll idx", int'(mem_idx), 7);
    host_set(7, mk(1, 1, 'h7000));
    wait_ready("R6 poll ready");
    chk("R6 idx", int'(buf_idx), 7);

    // R9: wrap past the last entry
    host_set(1, mk(1, 1, 'h1100));
    frame_end(7, 0);
    wait_ready("R9 wrap ready");
    chk("R9 wrap idx", int'(buf_idx), 1);
    chk("R4 wrap scrub", int'(mem[0][DW-1]), 0);

    // R10: full lap with no start entry
    for (int i = 0; i < N; i++) host_set(i, mk(0, 0, 'h100 * i));
    host_set(5, mk(1, 0, 'h5500));
    frame_end(1, 0);
    n = 0; while (mem_re && n < 20) begin n++; cyc(); end
    chk("R10 lap length", n, N);
    chk("R10 parked idx", int'(mem_idx), 2);
    chk("R4 lap scrub", int'(mem[5][DW-1]), 0);
    host_set(4, mk(1, 1, 'h4400));
    wait_ready("R10 ready after lap");
    chk("R10 idx", int'(buf_idx), 4);

    // R11: restart keeps the bit, returns to entry 0
    restart = 1; cyc(); restart = 0;
    chk("R11 restart la kept", int'(la_en), 1);
    chk("R11 restart valid", int'(buf_valid), 0);
    chk("R11 restart idx", int'(mem_idx), 0);
    la_wr = 1; la_wdata = 0; cyc(); la_wr = 0;
    chk("R11 la clear", int'(la_en), 0);
    repeat (4) cyc();
    summary();
  end
endmodule